// File: doc/BRIEF.md
# Tick-Paced Sample Sequencer

The sequencer plays a list of setpoint samples to an analog-output data port at a rate chosen by software. Software loads the samples into an internal FIFO in advance, then sets a tick limit (clock cycles between samples) and a command limit (how many samples to play), and raises the run input. From then on the pacing is done entirely in hardware. A tick counter paces the output. On each period boundary the next FIFO entry moves into the output register, and a one-cycle strobe marks the new value. Software therefore never has to synchronize with each sample.

After the last sample has been issued, a completion flag rises and the block goes idle, even if run stays high. If the FIFO runs dry when a sample is due, the output keeps its old value and a sticky underrun flag is raised. The tick count, the sample count, the completion flag and the FIFO fill level are all visible as status outputs.

Top module: `tick_seq`

## Requirements
- R1: After reset, out_data, out_valid, done, underrun, tick_cnt, cmd_cnt and fill are all zero, and full is low.
- R2: When wr_en is high and the FIFO is not full, wr_data is stored and fill rises by one. A write while full (fill equals DEPTH) is ignored and is never played.
- R3: In the cycle after run is first seen high, the oldest FIFO entry appears on out_data with out_valid high for that one cycle. At the same time cmd_cnt becomes 1, tick_cnt becomes 0 and done is cleared.
- R4: While running and not done, tick_cnt rises by one per clock. When the count would reach tick_limit it returns to 0 instead, so samples are issued every tick_limit cycles. A tick_limit of 0 or 1 means every cycle.
- R5: Each such wrap issues the next FIFO entry in write order with a one-cycle out_valid pulse, and cmd_cnt rises by one.
- R6: done goes high at the same edge that issues sample number cmd_limit (a cmd_limit of 0 acts as 1). Afterwards tick_cnt stays 0, cmd_cnt stays at cmd_limit, no entries are popped and out_valid stays low until the next rise of run. done stays high until that next rise.
- R7: If the FIFO is empty when a sample is due, out_data holds, out_valid stays low, underrun becomes 1 and stays 1 while run is high, and cmd_cnt still counts the slot.
- R8: While run is low, tick_cnt, cmd_cnt and underrun are forced to 0 from the next edge. out_data and done keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Push request into the sample FIFO |
| wr_data | input | DW | Sample to push |
| full | output | 1 | FIFO holds DEPTH entries |
| fill | output | $clog2(DEPTH)+1 | FIFO occupancy |
| run | input | 1 | Run enable; a rising edge starts a sequence |
| tick_limit | input | TW | Clock cycles per sample |
| cmd_limit | input | CW | Number of samples in the sequence |
| out_data | output | DW | Current setpoint |
| out_valid | output | 1 | One-cycle pulse when out_data takes a new sample |
| done | output | 1 | Sequence complete |
| underrun | output | 1 | Sticky flag: a sample was due while the FIFO was empty |
| tick_cnt | output | TW | Current tick count |
| cmd_cnt | output | CW | Samples issued in this sequence |

## Verification
The assertions assume that tick_limit and cmd_limit stay constant whenever run is high. The tick-range check would be meaningless if the limit moved under a running count. The bench therefore changes the limits only while run is low, one full cycle before raising it. Writes are issued only while run is low, so the fill level the bench expects depends on pops alone. Run is always held for at least one cycle before it is changed.

// File: rtl/tick_seq.sv
module tick_seq #(
  parameter int DW = 16,
  parameter int DEPTH = 16,
  parameter int TW = 24,
  parameter int CW = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  output logic [AW:0]   fill,
  input  logic          run,
  input  logic [TW-1:0] tick_limit,
  input  logic [CW-1:0] cmd_limit,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          done,
  output logic          underrun,
  output logic [TW-1:0] tick_cnt,
  output logic [CW-1:0] cmd_cnt
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wp, rp;
  logic          run_q;

  wire empty  = (wp == rp);
  assign full = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign fill = wp - rp;

  wire push   = wr_en && !full;
  wire start  = run && !run_q;
  wire active = run && run_q && !done;
  wire wrap   = active && (({1'b0, tick_cnt} + 1'b1) >= {1'b0, tick_limit});
  wire last   = (({1'b0, cmd_cnt} + 1'b1) >= {1'b0, cmd_limit});
  wire slot   = start || wrap;
  wire pop    = slot && !empty;

  always_ff @(posedge clk) begin
    if (push) mem[wp[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      tick_cnt  <= '0;
      cmd_cnt   <= '0;
      done      <= 1'b0;
      underrun  <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      run_q     <= run;
      out_valid <= pop;
      if (pop) out_data <= mem[rp[AW-1:0]];
      if (!run) begin
        tick_cnt <= '0;
        cmd_cnt  <= '0;
        underrun <= 1'b0;
      end else if (start) begin
        tick_cnt <= '0;
        cmd_cnt  <= CW'(1);
        done     <= (cmd_limit <= CW'(1));
        underrun <= empty;
      end else if (active) begin
        if (wrap) begin
          tick_cnt <= '0;
          cmd_cnt  <= cmd_cnt + 1'b1;
          done     <= last;
          if (empty) underrun <= 1'b1;
        end else begin
          tick_cnt <= tick_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tick_seq_chk.sv
module tick_seq_chk #(
  parameter int DW = 16,
  parameter int DEPTH = 16,
  parameter int TW = 24,
  parameter int CW = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          full,
  input logic [AW:0]   fill,
  input logic          run,
  input logic [TW-1:0] tick_limit,
  input logic [DW-1:0] out_data,
  input logic          out_valid,
  input logic          done,
  input logic          underrun,
  input logic [TW-1:0] tick_cnt,
  input logic [CW-1:0] cmd_cnt
);

  // R2
  full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> fill == (AW+1)'(DEPTH));

  // R4
  tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_limit > TW'(1)) |-> tick_cnt < tick_limit);

  // R5
  strobe_counted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> cmd_cnt != '0);

  // R6
  idle_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && done) |=> (!out_valid && $stable(out_data)));

  // R7
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && underrun) |=> underrun);

  // R8
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (tick_cnt == '0 && cmd_cnt == '0 && !underrun));

endmodule

bind tick_seq tick_seq_chk #(.DW(DW), .DEPTH(DEPTH), .TW(TW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .full(full), .fill(fill), .run(run),
  .tick_limit(tick_limit), .out_data(out_data), .out_valid(out_valid),
  .done(done), .underrun(underrun), .tick_cnt(tick_cnt), .cmd_cnt(cmd_cnt)
);

// File: tb/tick_seq_tb_top.sv
`timescale 1ns/1ps
module tick_seq_tb_top;
  localparam int DW = 8, DEPTH = 4, TW = 4, CW = 4;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, run = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [TW-1:0] tick_limit = '0;
  logic [CW-1:0] cmd_limit = '0;
  logic full, out_valid, done, underrun;
  logic [2:0] fill;
  logic [DW-1:0] out_data;
  logic [TW-1:0] tick_cnt;
  logic [CW-1:0] cmd_cnt;
  int total = 0, failed = 0;

  always #2.5 clk = ~clk;

  tick_seq #(.DW(DW), .DEPTH(DEPTH), .TW(TW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .fill(fill), .run(run), .tick_limit(tick_limit), .cmd_limit(cmd_limit),
    .out_data(out_data), .out_valid(out_valid), .done(done), .underrun(underrun),
    .tick_cnt(tick_cnt), .cmd_cnt(cmd_cnt));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input int first, input int count);
    for (int i = 0; i < count; i++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = DW'(first + i);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic start_run(input int l, input int n);
    tick_limit = TW'(l);
    cmd_limit = CW'(n);
    @(negedge clk);
    run = 1'b1;
    @(negedge clk);
  endtask

  task automatic stop_run();
    run = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 out_data", out_data, 0);
    check("R1 flags", {out_valid, done, underrun, full}, 0);
    check("R1 counters", tick_cnt + cmd_cnt + fill, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5 R6 sweep of tick and command limits
    for (int l = 1; l <= 4; l++) begin
      for (int n = 1; n <= 4; n++) begin
        int base, slot, held;
        base = l * 16 + n;
        push(base, n);
        check("R2 fill", fill, n);
        start_run(l, n);
        for (int k = 0; k <= n * l + 2; k++) begin
          slot = k / l;
          held = (slot < n) ? slot : n - 1;
          check("R3 R5 out_valid", out_valid, (k % l == 0 && slot < n) ? 1 : 0);
          check("R5 out_data", out_data, base + held);
          check("R5 R6 cmd_cnt", cmd_cnt, held + 1);
          check("R4 tick_cnt", tick_cnt, (k < (n - 1) * l) ? k % l : 0);
          check("R6 done", done, (k >= (n - 1) * l) ? 1 : 0);
          @(negedge clk);
        end
        check("R6 fifo untouched after done", fill, 0);
        stop_run();
        check("R8 counters cleared", tick_cnt + cmd_cnt, 0);
        check("R8 done held", done, 1);
        check("R8 out_data held", out_data, base + n - 1);
      end
    end

    // R2 writes while full are dropped
    push(8'hB0, 6);
    check("R2 fill at full", fill, DEPTH);
    check("R2 full flag", full, 1);
    start_run(1, 4);
    check("R3 first sample", out_data, 8'hB0);
    check("R3 done cleared", done, 0);
    repeat (3) @(negedge clk);
    check("R2 last stored sample", out_data, 8'hB3);
    check("R2 no extra entries", fill, 0);
    stop_run();

    // R7 underrun mid-sequence
    push(8'hA0, 2);
    start_run(2, 4);
    repeat (4) @(negedge clk);
    check("R7 no strobe", out_valid, 0);
    check("R7 data held", out_data, 8'hA1);
    check("R7 underrun set", underrun, 1);
    check("R7 slot counted", cmd_cnt, 3);
    repeat (2) @(negedge clk);
    check("R7 underrun sticky", underrun, 1);
    check("R6 done after underrun", done, 1);
    stop_run();
    check("R8 underrun cleared", underrun, 0);

    // R7 empty at start
    start_run(3, 2);
    check("R7 empty start strobe", out_valid, 0);
    check("R7 empty start flag", underrun, 1);
    stop_run();

    // R8 stop in the middle of a run
    push(8'hC0, 3);
    start_run(3, 3);
    repeat (4) @(negedge clk);
    check("R8 mid count before stop", cmd_cnt, 2);
    stop_run();
    check("R8 tick cleared", tick_cnt, 0);
    check("R8 cmd cleared", cmd_cnt, 0);
    check("R8 done stays low", done, 0);
    check("R8 data held", out_data, 8'hC1);
    check("R8 fifo kept", fill, 1);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule